// File: doc/BRIEF.md
# Over-Current Fault Latch Controller

This block watches a stream of signed current samples and raises a latched, active-low fault when the sample magnitude stays above a programmable limit for long enough. Short excursions are filtered out by a debounce timer. Once latched, the fault also forces the PWM measurement output off, so the measurement line is left at its released (pulled-up) level.

The fault is cleared only by watching the PWM measurement line. When that line is held low from outside for a minimum number of clock cycles, the fault releases. If the fault pin and the PWM pin are tied together, an asserted fault pulls the shared line low and the fault clears itself after the hold time. If the magnitude is still above the limit when the fault releases, the fault comes back on the next SYNC pulse rather than at once.

All durations are counted in system clock cycles. The PWM line level arrives asynchronously and goes through a two-flop synchronizer before it is used.

Top module: `oc_fault_ctrl`

## Requirements
- R1: The over-limit condition holds when the absolute value of `sample_i` (two's complement) is strictly greater than `limit_i` (unsigned). This applies to both polarities, including the most negative code. A magnitude equal to the limit is not over-limit.
- R2: If the condition is present at DEB_CYC consecutive rising clock edges, `fault_no` goes low right after the last of those edges.
- R3: A run of the condition that is shorter than DEB_CYC edges never asserts the fault. Any edge without the condition restarts the debounce count from zero.
- R4: Once asserted, the fault stays asserted when the condition goes away, for as long as the synchronized PWM line reads high.
- R5: `pwm_off_o` is high exactly while the fault is asserted (`fault_no` low).
- R6: `pwm_line_i` passes through two flops before use. If it is held low from a setup before edge 1 through edge RST_CYC, an asserted fault releases (`fault_no` high) right after edge RST_CYC+2.
- R7: A low pulse on `pwm_line_i` that lasts fewer than RST_CYC edges does not release the fault. The hold count restarts whenever the synchronized line reads high.
- R8: If the fault releases while the condition is still present, it is not re-asserted until a cycle in which `sync_i` is high. It is then asserted right after that edge.
- R9: With `pwm_line_i` tied to `fault_no`, an asserted fault releases RST_CYC+2 edges after it was set. With the condition still present, it re-asserts on the next `sync_i` pulse.
- R10: After reset, `fault_no` is high and `pwm_off_o` is low. Both counters are cleared, so a full debounce run is needed to assert the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Signed current sample |
| limit_i | input | SAMPLE_W | Unsigned magnitude limit |
| sync_i | input | 1 | One-cycle pulse marking a SYNC edge |
| pwm_line_i | input | 1 | Sensed level of the open-drain PWM line (asynchronous) |
| fault_no | output | 1 | Fault pin drive, active low |
| pwm_off_o | output | 1 | Forces the PWM measurement output to its released state |

## Verification
The checker assumes that `sync_i` is a single-cycle pulse in the clock domain. It also assumes that `sample_i` and `limit_i` are synchronous to the clock, so the comparison result is stable at each edge. Only `pwm_line_i` may change at any time. The bench drives every input on the falling clock edge, issues `sync_i` for one cycle at a time, and varies the PWM line only through explicit low pulses or through the tied connection to `fault_no`.

// File: rtl/oc_fault_pkg.sv
package oc_fault_pkg;
  function automatic int unsigned cnt_width(int unsigned limit);
    int unsigned w;
    w = $clog2(limit + 1);
    return (w < 1) ? 1 : w;
  endfunction
endpackage

// File: rtl/oc_mag_cmp.sv
module oc_mag_cmp #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] limit_i,
  output logic                over_o
);
  logic [SAMPLE_W-1:0] mag;

  // two's complement negate; the most negative code maps to 2^(W-1) unsigned
  always_comb begin
    if (sample_i[SAMPLE_W-1]) mag = ~sample_i + 1'b1;
    else                      mag = sample_i;
    over_o = mag > limit_i;
  end
endmodule

// File: rtl/oc_sync.sv
module oc_sync #(
  parameter int unsigned STAGES = 2,
  parameter bit          RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[i] <= RST_VAL;
      else if (i == 0) stg_q[i] <= d_i;
      else             stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/oc_run_cnt.sv
module oc_run_cnt
  import oc_fault_pkg::*;
#(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned W = cnt_width(LIMIT);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  // done on the LIMIT-th consecutive qualifying edge; saturates afterwards
  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/oc_fault_ctrl.sv
module oc_fault_ctrl #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned DEB_CYC  = 350,
  parameter int unsigned RST_CYC  = 50,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] limit_i,
  input  logic                sync_i,
  input  logic                pwm_line_i,
  output logic                fault_no,
  output logic                pwm_off_o
);
  logic over_w, deb_done_w, line_s_w, hold_done_w, trip_w;
  logic fault_q, armed_q;

  oc_mag_cmp #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .sample_i(sample_i), .limit_i(limit_i), .over_o(over_w)
  );

  oc_run_cnt #(.LIMIT(DEB_CYC)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(over_w), .done_o(deb_done_w)
  );

  oc_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_line_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pwm_line_i), .q_o(line_s_w)
  );

  oc_run_cnt #(.LIMIT(RST_CYC)) u_hold (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(fault_q & ~line_s_w), .done_o(hold_done_w)
  );

  // after a release with the condition still present, wait for a SYNC pulse
  assign trip_w = deb_done_w & (armed_q | sync_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      if (hold_done_w)  fault_q <= 1'b0;
      else if (trip_w)  fault_q <= 1'b1;
      if (hold_done_w)  armed_q <= 1'b0;
      else if (!over_w) armed_q <= 1'b1;
    end
  end

  assign fault_no  = ~fault_q;
  assign pwm_off_o = fault_q;
endmodule

// File: rtl/oc_fault_chk.sv
module oc_fault_chk #(
  parameter int unsigned DEB_CYC = 350,
  parameter int unsigned RST_CYC = 50
) (
  input logic clk_i,
  input logic rst_ni,
  input logic over_i,
  input logic line_s_i,
  input logic armed_i,
  input logic sync_i,
  input logic fault_i
);
  int unsigned over_run, low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      over_run <= 0;
      low_run  <= 0;
    end else begin
      if (!over_i)               over_run <= 0;
      else if (over_run < DEB_CYC) over_run <= over_run + 1;
      if (!(fault_i && !line_s_i)) low_run <= 0;
      else if (low_run < RST_CYC)  low_run <= low_run + 1;
    end
  end

  // R2
  deb_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_i) |-> ($past(over_i) && ($past(over_run) >= DEB_CYC - 1)));

  // R8
  relatch_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_i) |-> $past(armed_i || sync_i));

  // R4
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_i && line_s_i) |=> fault_i);

  // R6
  release_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_i) |-> $past(!line_s_i));

  // R7
  release_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_i) |-> ($past(low_run) >= RST_CYC - 1));
endmodule

bind oc_fault_ctrl oc_fault_chk #(.DEB_CYC(DEB_CYC), .RST_CYC(RST_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .over_i(over_w), .line_s_i(line_s_w),
  .armed_i(armed_q), .sync_i(sync_i), .fault_i(fault_q)
);

// File: tb/tb_oc_fault_ctrl.sv
module tb_oc_fault_ctrl;
  localparam int unsigned SW  = 16;
  localparam int unsigned DEB = 350;
  localparam int unsigned RST = 50;
  localparam logic [SW-1:0] LIM = 16'd1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [SW-1:0] sample = '0, limit = LIM;
  logic sync_p = 1'b0, line_drv = 1'b1, tie = 1'b0;
  logic fault_n, pwm_off, line;
  int n_chk = 0, n_fail = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;
  assign line = tie ? fault_n : line_drv;

  oc_fault_ctrl #(.SAMPLE_W(SW), .DEB_CYC(DEB), .RST_CYC(RST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .limit_i(limit),
    .sync_i(sync_p), .pwm_line_i(line), .fault_no(fault_n), .pwm_off_o(pwm_off)
  );

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sample = '0; sync_p = 1'b0; line_drv = 1'b1; tie = 1'b0;
    edges(2);
    rst_n = 1'b1;
    edges(1);
  endtask

  // drives a value and expects the fault exactly after DEB edges
  task automatic trip(logic [SW-1:0] v, string req);
    sample = v;
    edges(DEB - 1);
    chk(req, fault_n, 1'b1);
    edges(1);
    chk(req, fault_n, 1'b0);
    chk("R5", pwm_off, 1'b1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10", fault_n, 1'b1);
    chk("R10", pwm_off, 1'b0);
  endtask

  task automatic t_polarity();
    do_reset(); trip(16'd1001, "R2");
    do_reset(); trip(-16'sd1001, "R1");
    do_reset(); trip(16'h8000, "R1");
  endtask

  task automatic t_at_limit();
    do_reset();
    sample = LIM; edges(DEB + 5);
    chk("R1", fault_n, 1'b1);
    sample = -LIM; edges(DEB + 5);
    chk("R1", fault_n, 1'b1);
  endtask

  task automatic t_short();
    do_reset();
    for (int i = 0; i < 3; i++) begin
      sample = 16'd2000; edges(DEB - 1);
      sample = 16'd0;    edges(1);
    end
    chk("R3", fault_n, 1'b1);
    chk("R5", pwm_off, 1'b0);
  endtask

  task automatic t_latch_and_clear();
    do_reset();
    trip(16'd1500, "R2");
    sample = '0; edges(30);
    chk("R4", fault_n, 1'b0);
    chk("R5", pwm_off, 1'b1);
    line_drv = 1'b0; edges(RST - 1);
    line_drv = 1'b1; edges(10);
    chk("R7", fault_n, 1'b0);
    line_drv = 1'b0; edges(RST + 1);
    chk("R6", fault_n, 1'b0);
    edges(1);
    chk("R6", fault_n, 1'b1);
    chk("R5", pwm_off, 1'b0);
    line_drv = 1'b1;
  endtask

  task automatic t_relatch();
    do_reset();
    trip(16'd3000, "R2");
    line_drv = 1'b0; edges(RST + 2);
    chk("R6", fault_n, 1'b1);
    line_drv = 1'b1; edges(20);
    chk("R8", fault_n, 1'b1);
    sync_p = 1'b1; edges(1);
    sync_p = 1'b0;
    chk("R8", fault_n, 1'b0);
  endtask

  task automatic t_auto();
    do_reset();
    tie = 1'b1;
    trip(-16'sd5000, "R2");
    edges(RST + 1);
    chk("R9", fault_n, 1'b0);
    edges(1);
    chk("R9", fault_n, 1'b1);
    edges(15);
    chk("R9", fault_n, 1'b1);
    sync_p = 1'b1; edges(1);
    sync_p = 1'b0;
    chk("R9", fault_n, 1'b0);
    tie = 1'b0;
  endtask

  initial begin
    t_reset();
    t_polarity();
    t_at_limit();
    t_short();
    t_latch_and_clear();
    t_relatch();
    t_auto();
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule